// File: doc/BRIEF.md
# Head-Pointer Sharing-List Home Directory

This block is the home-side directory for a coherence scheme in which each memory block's sharers form a linked list held by the caches themselves. The home keeps only one entry per block: a head pointer naming the most recent sharer, and a three-valued state. The three states are UNCACHED (no remote copy), CLEAN_SHARED (read-only copies may exist and memory is current) and OWNED (a remote cache holds a writable copy, so memory may be stale).

Nodes send read misses, write misses and head-departure notices. For each request the directory returns the head it had before the request. It also says whether that head identity is meaningful, whether home memory can supply the data, and what the entry's state is after the update. A requestor that misses becomes the new head and links itself in front of the returned old head. A writer is then responsible for purging the rest of the list.

The directory handles one request per clock and answers one cycle after acceptance, with valid/ready flow control on both sides. The read and the update of an entry happen in the same cycle, so every access to a block is ordered at the home. A second writer that arrives while a block is OWNED receives the identity of the current owner and queues behind it.

Top module: `ll_home_dir`

## Requirements
- R1: After reset every entry is UNCACHED (state code 0) with head 0, and `rsp_valid` is low.
- R2: A read (op code 0) to an UNCACHED block answers prev_valid=0, mem_valid=1, new state CLEAN_SHARED (code 1), and makes the requestor the head.
- R3: A read to a CLEAN_SHARED block answers with the old head, prev_valid=1, mem_valid=1, keeps CLEAN_SHARED and makes the requestor the head.
- R4: A write (op code 1) in any state makes the requestor the head and the state OWNED (code 2). It returns the old head with prev_valid=1 unless the block was UNCACHED, and mem_valid=1 unless the block was OWNED.
- R5: For any request to an OWNED block the answer has mem_valid=0 and names the current owner as the old head. A read leaves the block OWNED with the reader as the new head.
- R6: A departure notice (op code 2) from the current head of a cached block, with the successor flag set, moves the head to the successor and leaves the state unchanged.
- R7: A departure notice from the current head with the successor flag clear returns the block to UNCACHED.
- R8: A departure notice from a node that is not the head, a departure notice to an UNCACHED block, and a query (op code 3) all leave the entry unchanged. The answer still reports the entry's current head and state.
- R9: A request accepted at a clock edge produces `rsp_valid` at the next edge. Back-to-back requests are accepted once per cycle, and entries of different blocks do not affect each other.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 read, 1 write, 2 head departure, 3 query |
| req_blk | input | BLK_W | Block index |
| req_node | input | NODE_W | Requesting node |
| req_succ_vld | input | 1 | Departing head has a successor |
| req_succ | input | NODE_W | Successor of the departing head |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_prev_head | output | NODE_W | Head before the request |
| rsp_prev_valid | output | 1 | Old head names a real sharer |
| rsp_mem_valid | output | 1 | Home memory may supply the data |
| rsp_state | output | 2 | Entry state after the request |

## Verification
The bench builds the directory with BLK_W=2 and NODE_W=3, so there are only four entries and eight nodes. With so few, random traffic keeps revisiting the same blocks and often hits the head-match case of departure notices. That brings the R6, R7 and R8 branches, writes to OWNED blocks and reads of OWNED blocks within reach many times. A random stall on `rsp_ready` exercises the hold behaviour of R10 against back-to-back requests of R9.

// File: rtl/lld_pkg.sv
package lld_pkg;
   typedef enum logic [1:0] {
      ST_UNCACHED = 2'd0,
      ST_CLEAN    = 2'd1,
      ST_OWNED    = 2'd2
   } dir_state_t;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_LEAVE = 2'd2,
      OP_QUERY = 2'd3
   } dir_op_t;
endpackage

// File: rtl/lld_entry_bank.sv
module lld_entry_bank
   import lld_pkg::*;
#(
   parameter int BLK_W  = 3,
   parameter int NODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BLK_W-1:0]  rd_blk,
   output dir_state_t        rd_state,
   output logic [NODE_W-1:0] rd_head,
   input  logic              wr_en,
   input  logic [BLK_W-1:0]  wr_blk,
   input  dir_state_t        wr_state,
   input  logic [NODE_W-1:0] wr_head
);
   localparam int ENTRIES = 1 << BLK_W;

   dir_state_t        st_q [ENTRIES];
   logic [NODE_W-1:0] hd_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_blk == BLK_W'(e));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[e] <= ST_UNCACHED;
            hd_q[e] <= '0;
         end else if (hit) begin
            st_q[e] <= wr_state;
            hd_q[e] <= wr_head;
         end
      end
   end

   assign rd_state = st_q[rd_blk];
   assign rd_head  = hd_q[rd_blk];

   // R4: a written OWNED entry is never rewritten to a value outside the encoding
   p_legal_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_state != dir_state_t'(2'd3)));
endmodule

// File: rtl/lld_next.sv
module lld_next
   import lld_pkg::*;
#(
   parameter int NODE_W = 4
) (
   input  dir_op_t           op,
   input  logic [NODE_W-1:0] node,
   input  logic              succ_vld,
   input  logic [NODE_W-1:0] succ,
   input  dir_state_t        cur_state,
   input  logic [NODE_W-1:0] cur_head,
   output logic              upd,
   output dir_state_t        nxt_state,
   output logic [NODE_W-1:0] nxt_head
);
   logic head_leaves;
   assign head_leaves = (cur_state != ST_UNCACHED) && (node == cur_head);

   always_comb begin
      upd       = 1'b0;
      nxt_state = cur_state;
      nxt_head  = cur_head;
      unique case (op)
         OP_READ: begin
            upd       = 1'b1;
            nxt_head  = node;
            nxt_state = (cur_state == ST_OWNED) ? ST_OWNED : ST_CLEAN;
         end
         OP_WRITE: begin
            upd       = 1'b1;
            nxt_head  = node;
            nxt_state = ST_OWNED;
         end
         OP_LEAVE: begin
            if (head_leaves) begin
               upd = 1'b1;
               if (succ_vld) begin
                  nxt_head = succ;
               end else begin
                  nxt_state = ST_UNCACHED;
                  nxt_head  = '0;
               end
            end
         end
         default: begin
            upd = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/lld_rsp_stage.sv
module lld_rsp_stage
   import lld_pkg::*;
#(
   parameter int NODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic [NODE_W-1:0] in_prev_head,
   input  logic              in_prev_valid,
   input  logic              in_mem_valid,
   input  dir_state_t        in_state,
   output logic              out_valid,
   output logic [NODE_W-1:0] out_prev_head,
   output logic              out_prev_valid,
   output logic              out_mem_valid,
   output dir_state_t        out_state
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         out_prev_head  <= '0;
         out_prev_valid <= 1'b0;
         out_mem_valid  <= 1'b0;
         out_state      <= ST_UNCACHED;
      end else if (load) begin
         out_valid      <= 1'b1;
         out_prev_head  <= in_prev_head;
         out_prev_valid <= in_prev_valid;
         out_mem_valid  <= in_mem_valid;
         out_state      <= in_state;
      end else if (take) begin
         out_valid <= 1'b0;
      end
   end

   // R10: a stalled response keeps its payload
   p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !take) |=> (out_valid && $stable(out_prev_head) &&
         $stable(out_prev_valid) && $stable(out_mem_valid) && $stable(out_state)));
endmodule

// File: rtl/ll_home_dir.sv
module ll_home_dir
   import lld_pkg::*;
#(
   parameter int BLK_W  = 3,
   parameter int NODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [BLK_W-1:0]  req_blk,
   input  logic [NODE_W-1:0] req_node,
   input  logic              req_succ_vld,
   input  logic [NODE_W-1:0] req_succ,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [NODE_W-1:0] rsp_prev_head,
   output logic              rsp_prev_valid,
   output logic              rsp_mem_valid,
   output logic [1:0]        rsp_state
);
   if (BLK_W < 1 || BLK_W > 10) begin : g_bad_blk
      $error("ll_home_dir: BLK_W out of range");
   end
   if (NODE_W < 1 || NODE_W > 16) begin : g_bad_node
      $error("ll_home_dir: NODE_W out of range");
   end

   dir_op_t           op;
   dir_state_t        cur_state, nxt_state, out_state;
   logic [NODE_W-1:0] cur_head, nxt_head;
   logic              upd, accept;

   assign op        = dir_op_t'(req_op);
   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   lld_entry_bank #(.BLK_W(BLK_W), .NODE_W(NODE_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_blk   (req_blk),
      .rd_state (cur_state),
      .rd_head  (cur_head),
      .wr_en    (accept && upd),
      .wr_blk   (req_blk),
      .wr_state (nxt_state),
      .wr_head  (nxt_head)
   );

   lld_next #(.NODE_W(NODE_W)) u_next (
      .op        (op),
      .node      (req_node),
      .succ_vld  (req_succ_vld),
      .succ      (req_succ),
      .cur_state (cur_state),
      .cur_head  (cur_head),
      .upd       (upd),
      .nxt_state (nxt_state),
      .nxt_head  (nxt_head)
   );

   lld_rsp_stage #(.NODE_W(NODE_W)) u_rsp (
      .clk            (clk),
      .rst_n          (rst_n),
      .load           (accept),
      .take           (rsp_ready),
      .in_prev_head   (cur_head),
      .in_prev_valid  (cur_state != ST_UNCACHED),
      .in_mem_valid   (cur_state != ST_OWNED),
      .in_state       (nxt_state),
      .out_valid      (rsp_valid),
      .out_prev_head  (rsp_prev_head),
      .out_prev_valid (rsp_prev_valid),
      .out_mem_valid  (rsp_mem_valid),
      .out_state      (out_state)
   );

   assign rsp_state = out_state;

   // R9: every accepted request is answered at the following edge
   p_answer_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);
   // R4: a write always leaves the block owned
   p_write_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_op == 2'd1) |=> (rsp_state == 2'd2));
   // R2: a read never leaves the block uncached
   p_read_cached_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_op == 2'd0) |=> (rsp_state != 2'd0));
   // R5: without a previous sharer, memory must be the data source
   p_no_head_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_prev_valid) |-> rsp_mem_valid);
   // R10: no acceptance while a response is stalled
   p_stall_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/ll_home_dir_test.sv
module ll_home_dir_test;
   localparam int BW = 2;
   localparam int NW = 3;
   localparam int NB = 1 << BW;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          req_valid = 0;
   logic          req_ready;
   logic [1:0]    req_op = 0;
   logic [BW-1:0] req_blk = 0;
   logic [NW-1:0] req_node = 0;
   logic          req_succ_vld = 0;
   logic [NW-1:0] req_succ = 0;
   logic          rsp_valid;
   logic          rsp_ready = 1;
   logic [NW-1:0] rsp_prev_head;
   logic          rsp_prev_valid;
   logic          rsp_mem_valid;
   logic [1:0]    rsp_state;

   int checks = 0;
   int errors = 0;
   bit stall_en = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ll_home_dir #(.BLK_W(BW), .NODE_W(NW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_blk(req_blk), .req_node(req_node), .req_succ_vld(req_succ_vld),
      .req_succ(req_succ), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_prev_head(rsp_prev_head), .rsp_prev_valid(rsp_prev_valid),
      .rsp_mem_valid(rsp_mem_valid), .rsp_state(rsp_state)
   );

   // reference model
   int    m_st [NB];
   int    m_hd [NB];
   bit    m_valid;
   int    m_prev, m_pv, m_mv, m_ns;
   string m_tag;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         m_valid = 0;
         for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_hd[i] = 0; end
      end else if (!done) begin
         int  b, s, h;
         bit  acc;
         chk("R9", "rsp_valid", int'(rsp_valid), int'(m_valid));
         chk("R10", "req_ready", int'(req_ready), int'(!m_valid || rsp_ready));
         if (m_valid && rsp_valid) begin
            chk(m_tag, "prev_head", int'(rsp_prev_head), m_prev);
            chk(m_tag, "prev_valid", int'(rsp_prev_valid), m_pv);
            chk(m_tag, "mem_valid", int'(rsp_mem_valid), m_mv);
            chk(m_tag, "state", int'(rsp_state), m_ns);
         end
         acc = req_valid && (!m_valid || rsp_ready);
         if (acc) begin
            b = int'(req_blk); s = m_st[b]; h = m_hd[b];
            m_prev = h; m_pv = (s != 0); m_mv = (s != 2);
            case (req_op)
               2'd0: begin
                  m_tag = (s == 0) ? "R2" : (s == 2) ? "R5" : "R3";
                  m_hd[b] = int'(req_node); m_st[b] = (s == 2) ? 2 : 1;
               end
               2'd1: begin
                  m_tag = (s == 2) ? "R5" : "R4";
                  m_hd[b] = int'(req_node); m_st[b] = 2;
               end
               2'd2: begin
                  if (s != 0 && int'(req_node) == h) begin
                     if (req_succ_vld) begin m_tag = "R6"; m_hd[b] = int'(req_succ); end
                     else begin m_tag = "R7"; m_st[b] = 0; m_hd[b] = 0; end
                  end else m_tag = "R8";
               end
               default: m_tag = "R8";
            endcase
            m_ns = m_st[b];
            m_valid = 1;
         end else if (rsp_ready) begin
            m_valid = 0;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (stall_en) rsp_ready = ($urandom % 4) != 0;
      else rsp_ready = 1;
   end

   // called at posedge+1; returns at posedge+1 after acceptance
   task automatic send(int op, int blk, int node, int sv, int succ);
      req_valid = 1; req_op = op[1:0]; req_blk = blk[BW-1:0];
      req_node = node[NW-1:0]; req_succ_vld = sv[0]; req_succ = succ[NW-1:0];
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic expect_now(string tag, int ph, int pv, int mv, int ns);
      @(negedge clk);
      chk(tag, "directed prev_head", int'(rsp_prev_head), ph);
      chk(tag, "directed prev_valid", int'(rsp_prev_valid), pv);
      chk(tag, "directed mem_valid", int'(rsp_mem_valid), mv);
      chk(tag, "directed state", int'(rsp_state), ns);
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
      @(posedge clk); #1;
      // R1: every entry starts uncached with head 0
      for (int b = 0; b < NB; b++) send(3, b, 0, 0, 0);
      req_valid = 0;
      @(posedge clk); #1;
      // directed walk on block 2, one request then a directed look
      send(0, 2, 1, 0, 0); req_valid = 0; expect_now("R2", 0, 0, 1, 1);
      send(0, 2, 5, 0, 0); req_valid = 0; expect_now("R3", 1, 1, 1, 1);
      send(1, 2, 3, 0, 0); req_valid = 0; expect_now("R4", 5, 1, 1, 2);
      send(1, 2, 6, 0, 0); req_valid = 0; expect_now("R5", 3, 1, 0, 2);
      send(0, 2, 4, 0, 0); req_valid = 0; expect_now("R5", 6, 1, 0, 2);
      send(2, 2, 1, 1, 7); req_valid = 0; expect_now("R8", 4, 1, 0, 2);
      send(2, 2, 4, 1, 6); req_valid = 0; expect_now("R6", 4, 1, 0, 2);
      send(3, 2, 0, 0, 0); req_valid = 0; expect_now("R6", 6, 1, 0, 2);
      send(2, 2, 6, 0, 0); req_valid = 0; expect_now("R7", 6, 1, 0, 0);
      send(2, 2, 0, 0, 0); req_valid = 0; expect_now("R8", 0, 0, 1, 0);
      send(3, 1, 0, 0, 0); req_valid = 0; expect_now("R9", 0, 0, 1, 0);
      // random traffic with back-pressure
      stall_en = 1;
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 5) == 0) begin
            req_valid = 0;
            @(posedge clk); #1;
         end else begin
            send(int'($urandom % 4), int'($urandom % NB), int'($urandom % 4),
                 int'($urandom % 2), int'($urandom % 8));
         end
      end
      req_valid = 0;
      stall_en = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule